// File: doc/BRIEF.md
# Supply Start-up and Protection Sequencer

This block is the digital sequencer for a two-stage power converter controller that holds a power-factor stage and a flyback stage. It takes comparator flags that are already digitized: three supply-level flags, high-voltage presence, latch-pin ready, control time-out, two mains-sense thresholds, a safe-restart fault request and a latched fault request. It runs these through a two-flop synchronizer. It then steps through charging, soft start, running, two fault-decay phases and a latched-off phase.

While the block is charging, it picks the high-voltage charge current from the supply band. The current is low near ground, high in the middle band, low again once the lockout level is passed, and off at the start-up level. A safe-restart fault (an external request, a control time-out while running, or supply collapse) shuts both converters and lets the supply fall so the block can start again. A latched fault shuts both converters for good. Only a mains low-then-high sequence or a full power removal releases that state.

Top module: `supply_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer enters the charging phase and clears its synchronizers. Both converter enables, both soft-start enables and the latch-pin source are then 0, and `chg_sel_o` reads 2'b01.
- R2: `chg_sel_o` codes are 2'b00 off, 2'b01 low and 2'b10 high, and 2'b11 never appears. In the charging phase the code is off at or above start-up, low between lockout and start-up, high between trip and lockout, and low below trip.
- R3: Every flag passes through two flops. A level change on a flag shows on the band-driven charge select two rising edges after it is driven, and on any phase change three edges after it is driven.
- R4: When the supply reaches start-up in the charging phase, the next phase sets charge to off and turns on the latch-pin source and both soft-start enables.
- R5: In soft start, latch-ready moves the block to running. Running enables both converters, drops both soft-starts and keeps the latch-pin source on.
- R6: If the supply falls below lockout in soft start before latch-ready is seen, the latch-pin source turns off and charging resumes.
- R7: A control time-out stops both converters while running, but it is ignored in soft start. After the stop, charge stays off until the supply is below lockout, and then charging resumes.
- R8: A safe-restart fault in soft start or running stops both converters and decays the supply, as in R7.
- R9: A latched fault (in charging, soft start, running or safe decay) stops both converters with charge off until the supply is below lockout. The block then enters the latched phase. There, charge follows the R2 band code, and the converters and the latch-pin source stay off whatever the supply does.
- R10: The latched phase is left for charging only when mains-low is seen and then, at a later cycle, mains-high. Mains-high alone has no effect.
- R11: In the latched phase or the latched decay, the block returns to charging when the supply is below trip and high voltage is absent.
- R12: While running, a supply drop below lockout stops both converters and returns the block straight to the charging phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_trip_i | input | 1 | Supply above trip level |
| vcc_uvlo_i | input | 1 | Supply above lockout level |
| vcc_start_i | input | 1 | Supply above start-up level |
| hv_ok_i | input | 1 | High-voltage input present |
| latch_rdy_i | input | 1 | Latch pin charged above its enable level |
| ctl_tmo_i | input | 1 | Control-voltage time-out reached |
| mains_low_i | input | 1 | Mains sense below its low reset threshold |
| mains_high_i | input | 1 | Mains sense above its high reset threshold |
| safe_flt_i | input | 1 | Safe-restart fault request |
| latch_flt_i | input | 1 | Latched fault request |
| chg_sel_o | output | 2 | Charge current: 00 off, 01 low, 10 high |
| latch_src_o | output | 1 | Latch-pin current source enable |
| pfc_ss_o | output | 1 | Power-factor stage soft-start enable |
| fb_ss_o | output | 1 | Flyback soft-start enable |
| pfc_en_o | output | 1 | Power-factor stage enable |
| fb_en_o | output | 1 | Flyback enable |

## Verification
The charge select follows the synchronized band combinationally, so it is due two rising edges after a flag is driven. Every output that depends on the phase is due three edges after. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge. It keeps a phase model with its own two-stage flag delay, so each compare lands on the cycle in which the result is due. The directed checks wait exactly two or three edges before they sample, and one check samples one edge early to confirm that the charge select has not yet moved.

// File: rtl/supply_seq.sv
`timescale 1ns/1ps
module supply_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_trip_i,
  input  logic       vcc_uvlo_i,
  input  logic       vcc_start_i,
  input  logic       hv_ok_i,
  input  logic       latch_rdy_i,
  input  logic       ctl_tmo_i,
  input  logic       mains_low_i,
  input  logic       mains_high_i,
  input  logic       safe_flt_i,
  input  logic       latch_flt_i,
  output logic [1:0] chg_sel_o,
  output logic       latch_src_o,
  output logic       pfc_ss_o,
  output logic       fb_ss_o,
  output logic       pfc_en_o,
  output logic       fb_en_o
);
  localparam int NF = 10;
  localparam int F_TRIP = 0, F_UVLO = 1, F_START = 2, F_HV = 3, F_RDY = 4,
                 F_TMO = 5, F_MLO = 6, F_MHI = 7, F_SFLT = 8, F_LFLT = 9;
  localparam logic [1:0] CHG_OFF = 2'b00, CHG_LOW = 2'b01, CHG_HIGH = 2'b10;

  typedef enum logic [2:0] {
    PH_CHARGE, PH_SOFT, PH_RUN, PH_SDECAY, PH_LDECAY, PH_LATCHED
  } phase_t;

  logic [NF-1:0] raw, s1, s2;
  phase_t        ph, ph_nx;
  logic          armed;
  logic          pwr_gone, restart_req;
  logic [1:0]    band_chg;

  assign raw = {latch_flt_i, safe_flt_i, mains_high_i, mains_low_i, ctl_tmo_i,
                latch_rdy_i, hv_ok_i, vcc_start_i, vcc_uvlo_i, vcc_trip_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  assign pwr_gone    = !s2[F_TRIP] && !s2[F_HV];
  assign restart_req = s2[F_SFLT] || s2[F_TMO];

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_CHARGE:
        if (s2[F_LFLT])        ph_nx = PH_LDECAY;
        else if (s2[F_START])  ph_nx = PH_SOFT;
      PH_SOFT:
        if (s2[F_LFLT])        ph_nx = PH_LDECAY;
        else if (s2[F_SFLT])   ph_nx = PH_SDECAY;
        else if (!s2[F_UVLO])  ph_nx = PH_CHARGE;
        else if (s2[F_RDY])    ph_nx = PH_RUN;
      PH_RUN:
        if (s2[F_LFLT])        ph_nx = PH_LDECAY;
        else if (restart_req)  ph_nx = PH_SDECAY;
        else if (!s2[F_UVLO])  ph_nx = PH_CHARGE;
      PH_SDECAY:
        if (s2[F_LFLT])        ph_nx = PH_LDECAY;
        else if (!s2[F_UVLO])  ph_nx = PH_CHARGE;
      PH_LDECAY:
        if (pwr_gone)          ph_nx = PH_CHARGE;
        else if (!s2[F_UVLO])  ph_nx = PH_LATCHED;
      PH_LATCHED:
        if (pwr_gone || (armed && s2[F_MHI])) ph_nx = PH_CHARGE;
      default:                 ph_nx = PH_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_CHARGE;
      armed <= 1'b0;
    end else begin
      ph    <= ph_nx;
      armed <= (ph == PH_LATCHED) && (armed || s2[F_MLO]);
    end
  end

  assign band_chg = s2[F_START] ? CHG_OFF  :
                    s2[F_UVLO]  ? CHG_LOW  :
                    s2[F_TRIP]  ? CHG_HIGH : CHG_LOW;

  assign chg_sel_o   = (ph == PH_CHARGE || ph == PH_LATCHED) ? band_chg : CHG_OFF;
  assign latch_src_o = (ph == PH_SOFT) || (ph == PH_RUN);
  assign pfc_ss_o    = (ph == PH_SOFT);
  assign fb_ss_o     = (ph == PH_SOFT);
  assign pfc_en_o    = (ph == PH_RUN);
  assign fb_en_o     = (ph == PH_RUN);
endmodule

// File: rtl/supply_seq_chk.sv
`timescale 1ns/1ps
module supply_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chg,
  input logic       src,
  input logic       pss,
  input logic       fss,
  input logic       pen,
  input logic       fen,
  input logic [9:0] flg
);
  // R2
  chg_code_chk: assert property (@(posedge clk) disable iff (!rst_n) chg != 2'b11);
  // R4
  ss_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pss || fss) |-> (chg == 2'b00 && src));
  // R5
  run_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pen || fen) |-> (src && pen && fen && !pss && !fss));
  // R7
  tmo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && flg[5]) |=> !fen);
  // R9
  lflt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && flg[9]) |=> (!fen && chg == 2'b00));
  // R12
  uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && !flg[1]) |=> !fen);
endmodule

bind supply_seq supply_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chg(chg_sel_o), .src(latch_src_o),
  .pss(pfc_ss_o), .fss(fb_ss_o), .pen(pfc_en_o), .fen(fb_en_o), .flg(s2)
);

// File: tb/supply_seq_tb.sv
`timescale 1ns/1ps
module supply_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vtrip = 0, vuvlo = 0, vstart = 0, hv = 0, rdy = 0, tmo = 0;
  logic mlo = 0, mhi = 0, sflt = 0, lflt = 0;
  logic [1:0] chg;
  logic src, pss, fss, pen, fen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  supply_seq u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_trip_i(vtrip), .vcc_uvlo_i(vuvlo),
    .vcc_start_i(vstart), .hv_ok_i(hv), .latch_rdy_i(rdy), .ctl_tmo_i(tmo),
    .mains_low_i(mlo), .mains_high_i(mhi), .safe_flt_i(sflt), .latch_flt_i(lflt),
    .chg_sel_o(chg), .latch_src_o(src), .pfc_ss_o(pss), .fb_ss_o(fss),
    .pfc_en_o(pen), .fb_en_o(fen)
  );

  // model: 0 charge, 1 soft, 2 run, 3 safe decay, 4 latched decay, 5 latched
  logic [9:0] m1, m2, rawv;
  int  mst;
  bit  marm;
  assign rawv = {lflt, sflt, mhi, mlo, tmo, rdy, hv, vstart, vuvlo, vtrip};

  function automatic int nxt(int s, logic [9:0] f, bit arm);
    bit off = !f[0] && !f[3];
    case (s)
      0: return f[9] ? 4 : f[2] ? 1 : 0;
      1: return f[9] ? 4 : f[8] ? 3 : !f[1] ? 0 : f[4] ? 2 : 1;
      2: return f[9] ? 4 : (f[8] || f[5]) ? 3 : !f[1] ? 0 : 2;
      3: return f[9] ? 4 : !f[1] ? 0 : 3;
      4: return off ? 0 : !f[1] ? 5 : 4;
      default: return (off || (arm && f[7])) ? 0 : 5;
    endcase
  endfunction

  function automatic logic [1:0] exp_chg(int s, logic [9:0] f);
    if (s != 0 && s != 5) return 2'b00;
    return f[2] ? 2'b00 : f[1] ? 2'b01 : f[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic string tag(int s);
    case (s)
      0: return "R2";  1: return "R4";  2: return "R5";
      3: return "R8";  4: return "R9";  default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; mst <= 0; marm <= 0;
    end else begin
      m1 <= rawv; m2 <= m1;
      mst <= nxt(mst, m2, marm);
      marm <= (mst == 5) && (marm || m2[6]);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_chk++;
      if (chg !== exp_chg(mst, m2) || src !== (mst == 1 || mst == 2) ||
          pss !== (mst == 1) || fss !== (mst == 1) ||
          pen !== (mst == 2) || fen !== (mst == 2)) begin
        n_fail++;
        $display("FAIL %s model: got chg=%b src=%b ss=%b%b en=%b%b exp chg=%b phase=%0d",
                 tag(mst), chg, src, pss, fss, pen, fen, exp_chg(mst, m2), mst);
      end
    end
  endtask

  task automatic chk(string r, logic [5:0] got, logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", r, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {chg, src, pss, pen, fen};
  endfunction

  task automatic set_vcc(int b);
    vtrip = (b >= 1); vuvlo = (b >= 2); vstart = (b >= 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk("R1", outs(), 6'b01_0000);
    @(negedge clk); rst_n = 1; hv = 1; set_vcc(1);
    tick(1); chk("R3", outs(), 6'b01_0000);
    tick(1); chk("R3", outs(), 6'b10_0000);
    set_vcc(2); tick(2); chk("R2", outs(), 6'b01_0000);
    set_vcc(3); tick(3); chk("R4", outs(), 6'b00_1100);
    tmo = 1; tick(3); chk("R7", outs(), 6'b00_1100);
    tmo = 0; set_vcc(1); tick(3); chk("R6", outs(), 6'b10_0000);
    set_vcc(3); tick(3); rdy = 1; tick(3); chk("R5", outs(), 6'b00_1011);
    tmo = 1; tick(3); chk("R7", outs(), 6'b00_0000);
    tmo = 0; set_vcc(1); tick(3); chk("R7", outs(), 6'b10_0000);
    set_vcc(3); tick(4); chk("R5", outs(), 6'b00_1011);
    sflt = 1; tick(3); chk("R8", outs(), 6'b00_0000);
    sflt = 0; set_vcc(1); tick(3); chk("R8", outs(), 6'b10_0000);
    set_vcc(3); tick(4);
    set_vcc(1); tick(3); chk("R12", outs(), 6'b10_0000);
    set_vcc(3); tick(4);
    lflt = 1; tick(3); chk("R9", outs(), 6'b00_0000);
    lflt = 0; set_vcc(2); tick(3); chk("R9", outs(), 6'b00_0000);
    set_vcc(1); tick(3); chk("R9", outs(), 6'b10_0000);
    set_vcc(3); tick(10); chk("R9", outs(), 6'b00_0000);
    mhi = 1; tick(5); chk("R10", outs(), 6'b00_0000);
    mhi = 0; mlo = 1; tick(3);
    mlo = 0; mhi = 1; tick(4); chk("R10", outs(), 6'b00_1100);
    mhi = 0; tick(2);
    lflt = 1; tick(3); lflt = 0;
    set_vcc(0); hv = 0; tick(3); chk("R11", outs(), 6'b01_0000);
    hv = 1; set_vcc(3); tick(3); chk("R11", outs(), 6'b00_1100);
    begin
      int b = 3, ml = 1;
      for (int i = 0; i < 4000; i++) begin
        case ($urandom % 8)
          0: if (b > 0) b--;
          1: if (b < 3) b++;
          default: ;
        endcase
        case ($urandom % 16)
          0: if (ml > 0) ml--;
          1: if (ml < 2) ml++;
          default: ;
        endcase
        set_vcc(b);
        hv   = ($urandom % 20) != 0;
        rdy  = ($urandom % 3) == 0;
        tmo  = ($urandom % 40) == 0;
        sflt = ($urandom % 60) == 0;
        lflt = ($urandom % 80) == 0;
        mlo  = (ml == 0);
        mhi  = (ml == 2);
        tick(1);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule